// File: doc/BRIEF.md
# Half-Duplex Radio Control Sequencer

This block sequences the control lines of a narrowband half-duplex radio module: the module power enable and two active-low mode selects, one for the transmitter and one for the receiver. A host asks for a channel change, for transmit, or for receive with one-cycle request pulses. The block answers with a `ready` flag that is high only once the radio is settled in its current mode, and with a `lock_err` flag when the synthesizer did not lock after a retune.

Retuning is always done from receive mode. The block starts an external synthesizer word loader with a start/done handshake, then waits a settling interval before it checks lock. The first retune after power-up waits longer than later ones. Every receive/transmit turnaround puts one cycle with both selects released between the two modes, followed by a shorter settling interval. On channels that carry an airtime limit, continuous transmit is cut off and a forced pause follows. All intervals are given in milliseconds and turned into clock cycles through a clock-rate parameter in kHz.

Top module: `hdx_radio_seq`

## Requirements
- R1: While reset is held, `pwr_en` is 0, `tx_sel_n` and `rx_sel_n` are 1, and `ready` and `lock_err` are 0. After release, `pwr_en` rises while both selects are still 1, and `rx_sel_n` falls exactly one cycle later.
- R2: `tx_sel_n` and `rx_sel_n` are never both 0. Whenever one select is released and the other is asserted, exactly one cycle with both at 1 lies between the two changes.
- R3: Until the first channel load has completed, `req_tx` and `req_rx` have no effect. `tx_sel_n` stays 1 and `ready` stays 0.
- R4: `req_chan` in receive mode raises `load_start` for exactly one cycle. `ready` rises FIRST_MS·CLK_KHZ cycles after the cycle in which `load_done` is sampled for the first load after reset, and RELOAD_MS·CLK_KHZ cycles after it for every later load.
- R5: Lock is judged in the last cycle of the post-load wait. If it is not locked, `lock_err` rises instead of `ready`, receive stays selected, and transmit requests are ignored until a later load succeeds. `lock_err` clears when that later load starts.
- R6: `lock_det` (1 = locked) passes through a two-flop synchronizer and must stay 1 for LOCK_STABLE consecutive cycles before it counts as locked. A level that toggles every cycle never counts as locked.
- R7: `req_tx` in receive-ready releases `rx_sel_n` on the next cycle and asserts `tx_sel_n` one cycle later. `ready` rises TURN_MS·CLK_KHZ cycles after that. `req_rx` in transmit-ready mirrors this sequence.
- R8: `req_chan` in transmit-ready first returns to receive. After the receive turnaround wait, `load_start` is raised. No load ever starts while `tx_sel_n` is 0.
- R9: With `limited_chan` held at 1, `tx_sel_n` stays 0 for at most TX_LIMIT_MS·CLK_KHZ consecutive cycles and is then released. A new transmit is not started until TX_PAUSE_MS·CLK_KHZ cycles after the release, even if `req_tx` is held.
- R10: With `limited_chan` at 0, transmit is held for as long as no request ends it.
- R11: `ready` is 1 only in a settled mode with exactly one select asserted. Outputs change only along the sequences above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_chan | input | 1 | Channel change request pulse |
| req_tx | input | 1 | Switch-to-transmit request |
| req_rx | input | 1 | Switch-to-receive request |
| limited_chan | input | 1 | Current channel carries an airtime limit |
| load_done | input | 1 | Synthesizer word loader finished |
| lock_det | input | 1 | Raw lock indicator from the radio, 1 = locked |
| load_start | output | 1 | One-cycle start pulse to the synthesizer loader |
| pwr_en | output | 1 | Radio module power enable |
| tx_sel_n | output | 1 | Transmit select, active low |
| rx_sel_n | output | 1 | Receive select, active low |
| ready | output | 1 | Radio settled in the present mode |
| lock_err | output | 1 | Last retune ended without lock |

## Verification
A corrupted sequencer state shows up at once on the select pins. It can release both selects in the wrong order, assert them together, or leave transmit on during a load, and each of these is visible on the cycle it happens. A wrong settling counter or a stale first-load flag shows no bad level at all. It shows only as a `ready` or `lock_err` edge placed a number of cycles off, so the bench measures the gap between every pair of consecutive output events against a window worked out from the requirements. A broken airtime guard shows only after the full limit or pause interval has passed, through a missing or early transmit edge.

// File: rtl/hdx_seq_pkg.sv
package hdx_seq_pkg;

  // Sequencer states; selects and power are decoded from these.
  typedef enum logic [3:0] {
    ST_OFF,        // reset: power off, both selects released
    ST_POWER,      // power on, both selects still released
    ST_UNTUNED,    // receive selected, no valid channel yet (or last lock failed)
    ST_LOAD_GO,    // start pulse to the synthesizer loader
    ST_LOAD_WAIT,  // waiting for loader done
    ST_SETTLE,     // post-load settling wait, lock judged at its end
    ST_RX_READY,   // receive settled
    ST_BRK_TX,     // both released on the way to transmit
    ST_TX_SETTLE,  // transmit selected, turnaround wait
    ST_TX_READY,   // transmit settled
    ST_BRK_RX,     // both released on the way to receive
    ST_RX_SETTLE   // receive selected, turnaround wait
  } seq_state_e;

  function automatic logic state_rx_on(seq_state_e s);
    return (s == ST_UNTUNED) || (s == ST_LOAD_GO) || (s == ST_LOAD_WAIT) ||
           (s == ST_SETTLE)  || (s == ST_RX_READY) || (s == ST_RX_SETTLE);
  endfunction

  function automatic logic state_tx_on(seq_state_e s);
    return (s == ST_TX_SETTLE) || (s == ST_TX_READY);
  endfunction

endpackage

// File: rtl/hdx_wait_timer.sv
// Down-counter for settling waits: a wait loaded with V-1 lasts V cycles.
module hdx_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/hdx_lock_filter.sv
// Two-flop synchronizer plus a stability counter for the raw lock level.
module hdx_lock_filter #(
  parameter int STABLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_raw,
  output logic locked
);

  localparam int CW = $clog2(STABLE + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(STABLE);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= lock_raw;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    run_en = !sync2_q || (run_q != CNT_TOP);
    run_d  = sync2_q ? (run_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign locked = (run_q == CNT_TOP);

endmodule

// File: rtl/hdx_air_guard.sv
// Airtime limit: counts continuous transmit on limited channels, cuts it,
// then holds a pause interval during which transmit may not restart.
module hdx_air_guard #(
  parameter longint unsigned LIMIT_CYC = 1000,
  parameter longint unsigned PAUSE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_on,
  input  logic limited,
  output logic cut,
  output logic pause
);

  localparam int AW = $clog2(LIMIT_CYC + 1);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam logic [AW-1:0] AIR_LAST  = AW'(LIMIT_CYC - 1);
  localparam logic [PW-1:0] PAUSE_TOP = PW'(PAUSE_CYC);

  logic [AW-1:0] air_q, air_d;
  logic          air_en;
  logic [PW-1:0] pau_q, pau_d;
  logic          pau_en;

  assign cut   = tx_on && limited && (air_q == AIR_LAST);
  assign pause = (pau_q != '0);

  always_comb begin
    air_en = 1'b1;
    if (!tx_on || !limited) air_d = '0;
    else if (cut)           begin air_d = air_q; air_en = 1'b0; end
    else                    air_d = air_q + 1'b1;
  end

  always_comb begin
    pau_en = cut || pause;
    pau_d  = cut ? PAUSE_TOP : (pau_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      air_q <= '0;
      pau_q <= '0;
    end else begin
      if (air_en) air_q <= air_d;
      if (pau_en) pau_q <= pau_d;
    end
  end

endmodule

// File: rtl/hdx_radio_seq.sv
module hdx_radio_seq
  import hdx_seq_pkg::*;
#(
  parameter int CLK_KHZ     = 50000,
  parameter int FIRST_MS    = 40,
  parameter int RELOAD_MS   = 20,
  parameter int TURN_MS     = 5,
  parameter int TX_LIMIT_MS = 40000,
  parameter int TX_PAUSE_MS = 2000,
  parameter int LOCK_STABLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_chan,
  input  logic req_tx,
  input  logic req_rx,
  input  logic limited_chan,
  input  logic load_done,
  input  logic lock_det,
  output logic load_start,
  output logic pwr_en,
  output logic tx_sel_n,
  output logic rx_sel_n,
  output logic ready,
  output logic lock_err
);

  localparam longint unsigned FIRST_CYC    = 64'(CLK_KHZ) * 64'(FIRST_MS);
  localparam longint unsigned RELOAD_CYC   = 64'(CLK_KHZ) * 64'(RELOAD_MS);
  localparam longint unsigned TURN_CYC     = 64'(CLK_KHZ) * 64'(TURN_MS);
  localparam longint unsigned TX_LIMIT_CYC = 64'(CLK_KHZ) * 64'(TX_LIMIT_MS);
  localparam longint unsigned TX_PAUSE_CYC = 64'(CLK_KHZ) * 64'(TX_PAUSE_MS);
  localparam longint unsigned WAIT_MAX_A   = (FIRST_CYC > RELOAD_CYC) ? FIRST_CYC : RELOAD_CYC;
  localparam longint unsigned WAIT_MAX     = (WAIT_MAX_A > TURN_CYC) ? WAIT_MAX_A : TURN_CYC;
  localparam int              TW           = $clog2(WAIT_MAX + 1);
  localparam logic [TW-1:0]   FIRST_VAL    = TW'(FIRST_CYC - 1);
  localparam logic [TW-1:0]   RELOAD_VAL   = TW'(RELOAD_CYC - 1);
  localparam logic [TW-1:0]   TURN_VAL     = TW'(TURN_CYC - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  seq_state_e    st_q, st_d;
  logic          loaded_q, loaded_set;
  logic          pend_q, pend_set, pend_clr;
  logic          err_q, err_set, err_clr;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          locked, air_cut, air_pause;

  hdx_wait_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  hdx_lock_filter #(.STABLE(LOCK_STABLE)) u_lock (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .lock_raw (lock_det),
    .locked   (locked)
  );

  hdx_air_guard #(.LIMIT_CYC(TX_LIMIT_CYC), .PAUSE_CYC(TX_PAUSE_CYC)) u_air (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tx_on   (state_tx_on(st_q)),
    .limited (limited_chan),
    .cut     (air_cut),
    .pause   (air_pause)
  );

  // Next-state logic.
  always_comb begin
    st_d       = st_q;
    tmr_load   = 1'b0;
    tmr_val    = TURN_VAL;
    loaded_set = 1'b0;
    pend_set   = 1'b0;
    pend_clr   = 1'b0;
    err_set    = 1'b0;
    err_clr    = 1'b0;
    unique case (st_q)
      ST_OFF:   st_d = ST_POWER;
      ST_POWER: st_d = ST_UNTUNED;
      ST_UNTUNED: begin
        // R3: only a channel load leaves this state
        if (req_chan) st_d = ST_LOAD_GO;
      end
      ST_LOAD_GO: begin
        pend_clr = 1'b1;
        err_clr  = 1'b1;
        st_d     = ST_LOAD_WAIT;
      end
      ST_LOAD_WAIT: begin
        if (load_done) begin
          st_d       = ST_SETTLE;
          tmr_load   = 1'b1;
          // R4: history-dependent settle length
          tmr_val    = loaded_q ? RELOAD_VAL : FIRST_VAL;
          loaded_set = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_exp) begin
          if (locked) st_d = ST_RX_READY;
          else begin
            st_d    = ST_UNTUNED;
            err_set = 1'b1;
          end
        end
      end
      ST_RX_READY: begin
        if (req_chan)                 st_d = ST_LOAD_GO;
        else if (req_tx && !air_pause) st_d = ST_BRK_TX;
      end
      ST_BRK_TX: begin
        st_d     = ST_TX_SETTLE;
        tmr_load = 1'b1;
      end
      ST_TX_SETTLE: begin
        if (air_cut)      st_d = ST_BRK_RX;
        else if (tmr_exp) st_d = ST_TX_READY;
      end
      ST_TX_READY: begin
        // R8: retune request while transmitting goes back to receive first
        if (req_chan) pend_set = 1'b1;
        if (air_cut || req_chan || req_rx) st_d = ST_BRK_RX;
      end
      ST_BRK_RX: begin
        st_d     = ST_RX_SETTLE;
        tmr_load = 1'b1;
      end
      ST_RX_SETTLE: begin
        if (tmr_exp) st_d = pend_q ? ST_LOAD_GO : ST_RX_READY;
      end
      default: st_d = ST_OFF;
    endcase
  end

  // State and flag registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q     <= ST_OFF;
      loaded_q <= 1'b0;
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (loaded_set)              loaded_q <= 1'b1;
      if (pend_set || pend_clr)    pend_q   <= pend_set;
      if (err_set || err_clr)      err_q    <= err_set;
    end
  end

  // Output decode from the registered state.
  always_comb begin
    pwr_en     = (st_q != ST_OFF);
    rx_sel_n   = !state_rx_on(st_q);
    tx_sel_n   = !state_tx_on(st_q);
    ready      = (st_q == ST_RX_READY) || (st_q == ST_TX_READY);
    load_start = (st_q == ST_LOAD_GO);
    lock_err   = err_q;
  end

endmodule

// File: rtl/hdx_radio_seq_chk.sv
module hdx_radio_seq_chk #(
  parameter longint unsigned LIMIT_CYC = 1000,
  parameter longint unsigned PAUSE_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic limited_chan,
  input logic load_start,
  input logic pwr_en,
  input logic tx_sel_n,
  input logic rx_sel_n,
  input logic ready,
  input logic lock_err
);

  logic [63:0] air_q;
  logic [63:0] pau_q;
  logic        tx_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      air_q  <= '0;
      pau_q  <= '0;
      tx_d_q <= 1'b1;
    end else begin
      tx_d_q <= tx_sel_n;
      air_q  <= (!tx_sel_n && limited_chan) ? air_q + 64'd1 : 64'd0;
      if (tx_sel_n && !tx_d_q && (air_q == LIMIT_CYC)) pau_q <= PAUSE_CYC;
      else if (pau_q != 0)                              pau_q <= pau_q - 64'd1;
    end
  end

  a_r1_power_before_select: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (tx_sel_n && rx_sel_n));

  a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(!tx_sel_n && !rx_sel_n));

  a_r2_tx_after_break: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_sel_n) |-> $past(rx_sel_n));

  a_r2_rx_after_break: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_sel_n) |-> $past(tx_sel_n));

  a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> !load_start);

  a_r8_load_only_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |-> (!rx_sel_n && tx_sel_n));

  a_r5_err_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> !ready);

  a_r11_ready_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (tx_sel_n != rx_sel_n));

  a_r9_airtime_bound: assert property (@(posedge clk) disable iff (!rst_n)
    air_q <= LIMIT_CYC);

  a_r9_pause_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_sel_n) |-> (pau_q == 0));

endmodule

bind hdx_radio_seq hdx_radio_seq_chk #(
  .LIMIT_CYC (TX_LIMIT_CYC),
  .PAUSE_CYC (TX_PAUSE_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .limited_chan (limited_chan),
  .load_start   (load_start),
  .pwr_en       (pwr_en),
  .tx_sel_n     (tx_sel_n),
  .rx_sel_n     (rx_sel_n),
  .ready        (ready),
  .lock_err     (lock_err)
);

// File: tb/hdx_radio_seq_tb_top.sv
module hdx_radio_seq_tb_top;

  // Scaled timing: one "ms" is one clock cycle.
  localparam int KHZ    = 1;
  localparam int FIRST  = 40;
  localparam int RELOAD = 20;
  localparam int TURN   = 5;
  localparam int LIM    = 300;
  localparam int PAUSE  = 60;
  localparam int STABLE = 4;
  localparam int ANY    = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_chan = 1'b0, req_tx = 1'b0, req_rx = 1'b0;
  logic limited_chan = 1'b0;
  logic load_done = 1'b0;
  logic lock_lvl = 1'b1, lock_toggle = 1'b0, tgl = 1'b0;
  logic lock_det;
  logic load_start, pwr_en, tx_sel_n, rx_sel_n, ready, lock_err;

  always #5 clk = ~clk;

  assign lock_det = lock_toggle ? tgl : lock_lvl;

  hdx_radio_seq #(
    .CLK_KHZ(KHZ), .FIRST_MS(FIRST), .RELOAD_MS(RELOAD), .TURN_MS(TURN),
    .TX_LIMIT_MS(LIM), .TX_PAUSE_MS(PAUSE), .LOCK_STABLE(STABLE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_chan(req_chan), .req_tx(req_tx), .req_rx(req_rx),
    .limited_chan(limited_chan), .load_done(load_done), .lock_det(lock_det),
    .load_start(load_start), .pwr_en(pwr_en), .tx_sel_n(tx_sel_n), .rx_sel_n(rx_sel_n),
    .ready(ready), .lock_err(lock_err)
  );

  typedef enum int {EV_PWR, EV_RXON, EV_RXOFF, EV_TXON, EV_TXOFF, EV_LOAD, EV_READY, EV_ERR} ev_e;
  typedef struct { ev_e kind; int lo; int hi; string tag; } exp_t;

  exp_t  exp_q[$];
  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic expect_ev(ev_e k, int lo, int hi, string tag);
    exp_t e;
    e.kind = k; e.lo = lo; e.hi = hi; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Scoreboard monitor: pops one expectation per observed output event.
  int   gap = 0;
  logic p_pwr = 1'b0, p_rx = 1'b1, p_tx = 1'b1, p_rdy = 1'b0, p_err = 1'b0;

  task automatic seen(ev_e k);
    exp_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, cur_tag, $sformatf("unexpected event %s", k.name()), k, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == k, e.tag, "event kind", k, e.kind);
      check(gap >= e.lo && gap <= e.hi, e.tag,
            $sformatf("cycles before %s (window up to %0d)", k.name(), e.hi), gap, e.lo);
    end
    gap = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        gap++;
        if (pwr_en && !p_pwr)         seen(EV_PWR);
        if (!rx_sel_n && p_rx)        seen(EV_RXON);
        if (rx_sel_n && !p_rx)        seen(EV_RXOFF);
        if (!tx_sel_n && p_tx)        seen(EV_TXON);
        if (tx_sel_n && !p_tx)        seen(EV_TXOFF);
        if (load_start)               seen(EV_LOAD);
        if (ready && !p_rdy)          seen(EV_READY);
        if (lock_err && !p_err)       seen(EV_ERR);
        p_pwr = pwr_en; p_rx = rx_sel_n; p_tx = tx_sel_n; p_rdy = ready; p_err = lock_err;
      end
    end
  end

  // Synthesizer loader model: done two cycles after the start pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (load_start) begin
        @(negedge clk);
        @(negedge clk);
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      tgl = ~tgl;
    end
  end

  task automatic pulse_chan(); @(negedge clk); req_chan = 1'b1; @(negedge clk); req_chan = 1'b0; endtask
  task automatic pulse_tx();   @(negedge clk); req_tx   = 1'b1; @(negedge clk); req_tx   = 1'b0; endtask
  task automatic pulse_rx();   @(negedge clk); req_rx   = 1'b1; @(negedge clk); req_rx   = 1'b0; endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state, then power before receive select
    repeat (3) @(negedge clk);
    check(pwr_en == 1'b0,   "R1", "pwr_en in reset",   pwr_en, 0);
    check(tx_sel_n == 1'b1, "R1", "tx_sel_n in reset", tx_sel_n, 1);
    check(rx_sel_n == 1'b1, "R1", "rx_sel_n in reset", rx_sel_n, 1);
    check(ready == 1'b0,    "R1", "ready in reset",    ready, 0);
    check(lock_err == 1'b0, "R1", "lock_err in reset", lock_err, 0);
    expect_ev(EV_PWR, 0, ANY, "R1");
    expect_ev(EV_RXON, 1, 1, "R1");
    rst_n = 1'b1;
    drain();

    // R3: mode requests before any channel load do nothing
    cur_tag = "R3";
    pulse_tx();
    pulse_rx();
    repeat (10) @(negedge clk);
    check(tx_sel_n == 1'b1, "R3", "tx_sel_n untuned", tx_sel_n, 1);
    check(ready == 1'b0,    "R3", "ready untuned",    ready, 0);

    // R4: first load waits the long interval
    cur_tag = "R4";
    expect_ev(EV_LOAD, 0, ANY, "R4");
    expect_ev(EV_READY, FIRST + 3, FIRST + 3, "R4");
    pulse_chan();
    drain();
    check(ready == 1'b1 && rx_sel_n == 1'b0, "R4", "ready in receive", ready, 1);

    // R4: later load waits the short interval
    expect_ev(EV_LOAD, 0, ANY, "R4");
    expect_ev(EV_READY, RELOAD + 3, RELOAD + 3, "R4");
    pulse_chan();
    drain();

    // R7: receive to transmit and back
    cur_tag = "R7";
    expect_ev(EV_RXOFF, 0, ANY, "R7");
    expect_ev(EV_TXON, 1, 1, "R2");
    expect_ev(EV_READY, TURN, TURN, "R7");
    pulse_tx();
    drain();
    check(tx_sel_n == 1'b0 && rx_sel_n == 1'b1, "R7", "transmit selected", tx_sel_n, 0);
    expect_ev(EV_TXOFF, 0, ANY, "R7");
    expect_ev(EV_RXON, 1, 1, "R2");
    expect_ev(EV_READY, TURN, TURN, "R7");
    pulse_rx();
    drain();

    // R8: channel change requested while transmitting
    expect_ev(EV_RXOFF, 0, ANY, "R7");
    expect_ev(EV_TXON, 1, 1, "R7");
    expect_ev(EV_READY, TURN, TURN, "R7");
    pulse_tx();
    drain();
    cur_tag = "R8";
    expect_ev(EV_TXOFF, 0, ANY, "R8");
    expect_ev(EV_RXON, 1, 1, "R8");
    expect_ev(EV_LOAD, TURN, TURN, "R8");
    expect_ev(EV_READY, RELOAD + 3, RELOAD + 3, "R8");
    pulse_chan();
    drain();
    check(rx_sel_n == 1'b0 && tx_sel_n == 1'b1, "R8", "receive after retune", rx_sel_n, 0);

    // R5: no lock at the end of the wait
    cur_tag = "R5";
    lock_lvl = 1'b0;
    repeat (6) @(negedge clk);
    expect_ev(EV_LOAD, 0, ANY, "R5");
    expect_ev(EV_ERR, RELOAD + 3, RELOAD + 3, "R5");
    pulse_chan();
    drain();
    check(lock_err == 1'b1, "R5", "lock_err raised", lock_err, 1);
    check(ready == 1'b0,    "R5", "ready after unlock", ready, 0);
    check(rx_sel_n == 1'b0, "R5", "receive kept", rx_sel_n, 0);
    pulse_tx();
    repeat (10) @(negedge clk);
    check(tx_sel_n == 1'b1, "R5", "transmit refused unlocked", tx_sel_n, 1);
    lock_lvl = 1'b1;
    repeat (6) @(negedge clk);
    expect_ev(EV_LOAD, 0, ANY, "R5");
    expect_ev(EV_READY, RELOAD + 3, RELOAD + 3, "R5");
    pulse_chan();
    drain();
    check(lock_err == 1'b0, "R5", "lock_err cleared", lock_err, 0);

    // R6: chattering lock never qualifies
    cur_tag = "R6";
    lock_toggle = 1'b1;
    expect_ev(EV_LOAD, 0, ANY, "R6");
    expect_ev(EV_ERR, RELOAD + 3, RELOAD + 3, "R6");
    pulse_chan();
    drain();
    check(lock_err == 1'b1, "R6", "toggling lock rejected", lock_err, 1);
    lock_toggle = 1'b0;
    repeat (6) @(negedge clk);
    expect_ev(EV_LOAD, 0, ANY, "R6");
    expect_ev(EV_READY, RELOAD + 3, RELOAD + 3, "R6");
    pulse_chan();
    drain();

    // R9: airtime cut and forced pause
    cur_tag = "R9";
    limited_chan = 1'b1;
    expect_ev(EV_RXOFF, 0, ANY, "R9");
    expect_ev(EV_TXON, 1, 1, "R9");
    expect_ev(EV_READY, TURN, TURN, "R9");
    expect_ev(EV_TXOFF, LIM - TURN, LIM - TURN, "R9");
    expect_ev(EV_RXON, 1, 1, "R9");
    expect_ev(EV_READY, TURN, TURN, "R9");
    pulse_tx();
    drain();
    expect_ev(EV_RXOFF, PAUSE - TURN, PAUSE - TURN, "R9");
    expect_ev(EV_TXON, 1, 1, "R9");
    expect_ev(EV_READY, TURN, TURN, "R9");
    limited_chan = 1'b0;
    req_tx = 1'b1;
    repeat (20) @(negedge clk);
    check(tx_sel_n == 1'b1, "R9", "transmit held off in pause", tx_sel_n, 1);
    drain();
    req_tx = 1'b0;

    // R10: no limit, transmit stays on
    cur_tag = "R10";
    repeat (LIM + 50) @(negedge clk);
    check(tx_sel_n == 1'b0, "R10", "transmit beyond limit", tx_sel_n, 0);
    check(ready == 1'b1,    "R10", "ready beyond limit",    ready, 1);
    expect_ev(EV_TXOFF, 0, ANY, "R10");
    expect_ev(EV_RXON, 1, 1, "R10");
    expect_ev(EV_READY, TURN, TURN, "R10");
    pulse_rx();
    drain();

    cur_tag = "R11";
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R11", "pending expectations", exp_q.size(), 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule